// File: doc/BRIEF.md
# Weighted Score Combiner with Offset, Alignment Delay and Cascade Sum

This datapath follows a binary correlation array. Each cycle it receives one agreement count per bit plane. It weights those counts according to the selected sample format and sums them into a signed score. It then adds a programmed signed offset. The adjusted score passes through a delay line of programmable length. A saturating adder then combines it with the partial score arriving from an upstream correlator, and the result is driven downstream.

The delay lets several correlators in a chain present time-aligned partial scores. A correlator further down the chain sets a longer delay so that its score meets the sums coming from the earlier correlators. The fixed latency from the plane counts to the cascade output is three clocks plus the programmed delay. The cascade input is registered once, which is one clock. Upstream delay settings are worked out from these two figures.

An auxiliary output shows either the raw count total or the weighted score. The weighted score on this output is taken before the offset is added and is clipped to the output width. Three registers set the format, the offset and the delay. They are loaded through a small write-only configuration port.

Top module: `score_cascade`

## Requirements
- R1: Plane k is counted at bit `k*6 +: 6` of `plane_cnt_i`. The format code in config bits [1:0] selects a group size G of 1, 2, 4 or 8 planes (codes 0 to 3). Plane k is weighted by 2 to the power (k mod G).
- R2: When config bit 2 (signed samples) is set, the highest plane of every group carries a negative weight of the same magnitude. This includes the single plane of each group when G is 1.
- R3: The 13-bit two's-complement offset held at config address 1 is added to the weighted score before the delay line.
- R4: The delay length D (0 to 15) is held in bits [3:0] at config address 2. A change on `plane_cnt_i` shows on `cas_o` exactly 3+D rising edges later, with D=0 giving 3. A change on `cas_i` shows on `cas_o` after one edge.
- R5: `cas_o` is the sum of the delayed score and `cas_i`, clipped to the range -4096 to +4095 instead of wrapping.
- R6: When config bit 3 is 0, `aux_o` shows the unsigned total of all plane counts. When bit 3 is 1, it shows the weighted score before the offset, clipped to -256 to +255. Either way it follows `plane_cnt_i` after two edges.
- R7: A write updates only the register selected by `cfg_addr_i`: 0 = format, 1 = offset, 2 = delay. A write to address 3 changes nothing.
- R8: While `rst_ni` is low, `cas_o` and `aux_o` read zero and all configuration fields are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 2 | Configuration register select |
| cfg_wdata_i | input | 13 | Configuration write data |
| plane_cnt_i | input | 48 | Agreement count of each of the 8 bit planes, 6 bits each |
| cas_i | input | 13 | Signed partial score from the upstream correlator |
| cas_o | output | 13 | Signed saturated cascade sum |
| aux_o | output | 9 | Raw count total or clipped weighted score |

## Verification
The hardest thing to confirm from the ports is the exact delay-line tap. Under steady inputs every delay setting gives the same output, so a wrong tap cannot be seen. The stimulus therefore holds the counts at zero long enough to flush the line. It then applies a one-cycle count pulse and samples `cas_o` one edge before, at, and one edge after the expected arrival, for delays of 0, 5 and 15. Saturation is reached from both the offset and the cascade input, with values that land exactly on and just past each limit.

// File: rtl/score_cascade_pkg.sv
package score_cascade_pkg;

  typedef struct packed {
    logic       aux_wtd;  // aux shows weighted score
    logic       sgn;      // two's-complement samples
    logic [1:0] grp;      // log2 of planes per sample
  } fmt_t;

  localparam int FMT_W = 4;

  typedef enum logic [1:0] {
    ADDR_FMT = 2'd0,
    ADDR_OFF = 2'd1,
    ADDR_DLY = 2'd2,
    ADDR_RSV = 2'd3
  } cfg_addr_e;

endpackage

// File: rtl/score_weight.sv
module score_weight #(
  parameter int NP    = 8,
  parameter int CNT_W = 6,
  parameter int W_W   = 15,
  parameter int RAW_W = 9
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NP*CNT_W-1:0]     cnt_i,
  input  logic [1:0]              grp_i,
  input  logic                    sgn_i,
  output logic signed [W_W-1:0]   wsum_o,
  output logic [RAW_W-1:0]        raw_o
);
  localparam int POS_W = 3;

  logic [POS_W-1:0]      top_pos;
  logic signed [W_W-1:0] term [NP];
  logic [RAW_W-1:0]      cnt_ext [NP];
  logic signed [W_W-1:0] wsum_d;
  logic [RAW_W-1:0]      raw_d;

  assign top_pos = POS_W'((1 << grp_i) - 1);

  for (genvar k = 0; k < NP; k++) begin : g_plane
    logic [POS_W-1:0]      pos;
    logic signed [W_W-1:0] mag;
    assign pos        = POS_W'(k) & top_pos;
    assign mag        = $signed({{(W_W-CNT_W){1'b0}}, cnt_i[k*CNT_W +: CNT_W]}) <<< pos;
    assign term[k]    = (sgn_i && (pos == top_pos)) ? -mag : mag;
    assign cnt_ext[k] = RAW_W'(cnt_i[k*CNT_W +: CNT_W]);
  end

  always_comb begin
    wsum_d = '0;
    raw_d  = '0;
    for (int k = 0; k < NP; k++) begin
      wsum_d = wsum_d + term[k];
      raw_d  = raw_d + cnt_ext[k];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wsum_o <= '0;
      raw_o  <= '0;
    end else begin
      wsum_o <= wsum_d;
      raw_o  <= raw_d;
    end
  end

endmodule

// File: rtl/score_delay.sv
module score_delay #(
  parameter int W       = 16,
  parameter int MAX_DLY = 15,
  parameter int DLY_W   = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [W-1:0]     d_i,
  input  logic [DLY_W-1:0] sel_i,
  output logic [W-1:0]     q_o
);
  logic [W-1:0] line [MAX_DLY];

  for (genvar i = 0; i < MAX_DLY; i++) begin : g_tap
    logic [W-1:0] src;
    if (i == 0) begin : g_head
      assign src = d_i;
    end else begin : g_body
      assign src = line[i-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) line[i] <= '0;
      else         line[i] <= src;
    end
  end

  // sel 0 bypasses the line; out-of-range values also bypass
  always_comb begin
    q_o = d_i;
    for (int i = 0; i < MAX_DLY; i++) begin
      if (sel_i == DLY_W'(i + 1)) q_o = line[i];
    end
  end

endmodule

// File: rtl/score_casadd.sv
module score_casadd #(
  parameter int IN_W  = 16,
  parameter int CAS_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IN_W-1:0]  a_i,
  input  logic [CAS_W-1:0] cas_i,
  output logic [CAS_W-1:0] cas_o
);
  localparam int S_W = IN_W + 1;
  localparam logic signed [S_W-1:0] MAX_V = S_W'(2**(CAS_W-1) - 1);
  localparam logic signed [S_W-1:0] MIN_V = ~MAX_V;

  logic signed [S_W-1:0] sum;
  logic [CAS_W-1:0]      clip;

  assign sum = $signed({a_i[IN_W-1], a_i}) +
               $signed({{(S_W-CAS_W){cas_i[CAS_W-1]}}, cas_i});

  always_comb begin
    if (sum > MAX_V)      clip = MAX_V[CAS_W-1:0];
    else if (sum < MIN_V) clip = MIN_V[CAS_W-1:0];
    else                  clip = sum[CAS_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cas_o <= '0;
    else         cas_o <= clip;
  end

endmodule

// File: rtl/score_cascade.sv
module score_cascade
  import score_cascade_pkg::*;
#(
  parameter  int NUM_PLANES = 8,
  parameter  int TAPS       = 32,
  parameter  int CAS_W      = 13,
  parameter  int AUX_W      = 9,
  parameter  int MAX_DLY    = 15,
  localparam int CNT_W      = $clog2(TAPS + 1)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        cfg_we_i,
  input  logic [1:0]                  cfg_addr_i,
  input  logic [CAS_W-1:0]            cfg_wdata_i,
  input  logic [NUM_PLANES*CNT_W-1:0] plane_cnt_i,
  input  logic [CAS_W-1:0]            cas_i,
  output logic [CAS_W-1:0]            cas_o,
  output logic [AUX_W-1:0]            aux_o
);
  localparam int DLY_W = $clog2(MAX_DLY + 1);
  localparam int W_W   = CNT_W + NUM_PLANES + 1;
  localparam int RAW_W = CNT_W + $clog2(NUM_PLANES);
  localparam int O_W   = ((W_W > CAS_W) ? W_W : CAS_W) + 1;
  localparam logic signed [W_W-1:0] AUX_HI = W_W'(2**(AUX_W-1) - 1);
  localparam logic signed [W_W-1:0] AUX_LO = ~AUX_HI;
  localparam int RAW_CAP = 2**AUX_W - 1;

  fmt_t                    fmt_q;
  logic signed [CAS_W-1:0] off_q;
  logic [DLY_W-1:0]        dly_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fmt_q <= '0;
      off_q <= '0;
      dly_q <= '0;
    end else if (cfg_we_i) begin
      case (cfg_addr_e'(cfg_addr_i))
        ADDR_FMT: fmt_q <= fmt_t'(cfg_wdata_i[FMT_W-1:0]);
        ADDR_OFF: off_q <= cfg_wdata_i;
        ADDR_DLY: dly_q <= cfg_wdata_i[DLY_W-1:0];
        default:  ;
      endcase
    end
  end

  logic signed [W_W-1:0] wsum_q;
  logic [RAW_W-1:0]      raw_q;

  score_weight #(
    .NP(NUM_PLANES), .CNT_W(CNT_W), .W_W(W_W), .RAW_W(RAW_W)
  ) i_weight (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cnt_i (plane_cnt_i),
    .grp_i (fmt_q.grp),
    .sgn_i (fmt_q.sgn),
    .wsum_o(wsum_q),
    .raw_o (raw_q)
  );

  logic signed [O_W-1:0] score_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) score_q <= '0;
    else score_q <= $signed({{(O_W-W_W){wsum_q[W_W-1]}}, wsum_q}) +
                    $signed({{(O_W-CAS_W){off_q[CAS_W-1]}}, off_q});
  end

  logic [O_W-1:0] dly_out;

  score_delay #(
    .W(O_W), .MAX_DLY(MAX_DLY), .DLY_W(DLY_W)
  ) i_delay (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (score_q),
    .sel_i (dly_q),
    .q_o   (dly_out)
  );

  score_casadd #(
    .IN_W(O_W), .CAS_W(CAS_W)
  ) i_casadd (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .a_i   (dly_out),
    .cas_i (cas_i),
    .cas_o (cas_o)
  );

  logic [AUX_W-1:0] aux_d;

  always_comb begin
    if (fmt_q.aux_wtd) begin
      if (wsum_q > AUX_HI)      aux_d = AUX_HI[AUX_W-1:0];
      else if (wsum_q < AUX_LO) aux_d = AUX_LO[AUX_W-1:0];
      else                      aux_d = wsum_q[AUX_W-1:0];
    end else begin
      if (int'(raw_q) > RAW_CAP) aux_d = '1;
      else                       aux_d = AUX_W'(raw_q);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) aux_o <= '0;
    else         aux_o <= aux_d;
  end

endmodule

// File: rtl/score_cascade_chk.sv
module score_cascade_chk #(
  parameter int O_W   = 16,
  parameter int CAS_W = 13,
  parameter int DLY_W = 4
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  cfg_we_i,
  input logic [1:0]            cfg_addr_i,
  input logic [CAS_W-1:0]      cfg_wdata_i,
  input logic [DLY_W-1:0]      dly_q,
  input logic signed [O_W-1:0] score_q,
  input logic [O_W-1:0]        dly_out,
  input logic [CAS_W-1:0]      cas_i,
  input logic [CAS_W-1:0]      cas_o
);
  localparam logic signed [O_W:0] HI = (O_W+1)'(2**(CAS_W-1) - 1);
  localparam logic signed [O_W:0] LO = ~HI;

  logic signed [O_W:0] wide;
  assign wide = $signed({dly_out[O_W-1], dly_out}) +
                $signed({{(O_W+1-CAS_W){cas_i[CAS_W-1]}}, cas_i});

  p_dly_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dly_q == '0) |-> (dly_out == score_q));

  p_dly_one_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dly_q == DLY_W'(1) && $past(dly_q) == DLY_W'(1)) |-> (dly_out == $past(score_q)));

  p_sat_hi_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wide > HI) |=> (cas_o == HI[CAS_W-1:0]));

  p_sat_lo_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wide < LO) |=> (cas_o == LO[CAS_W-1:0]));

  p_pass_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wide <= HI && wide >= LO) |=> (cas_o == $past(wide[CAS_W-1:0])));

  p_cfg_delay_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_addr_i == 2'd2) |=> (dly_q == $past(cfg_wdata_i[DLY_W-1:0])));

  p_cfg_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(cfg_we_i && cfg_addr_i == 2'd2)) |=> $stable(dly_q));

endmodule

bind score_cascade score_cascade_chk #(
  .O_W(O_W), .CAS_W(CAS_W), .DLY_W(DLY_W)
) i_score_cascade_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_we_i   (cfg_we_i),
  .cfg_addr_i (cfg_addr_i),
  .cfg_wdata_i(cfg_wdata_i),
  .dly_q      (dly_q),
  .score_q    (score_q),
  .dly_out    (dly_out),
  .cas_i      (cas_i),
  .cas_o      (cas_o)
);

// File: tb/test_score_cascade.sv
`timescale 1ns/1ps
module test_score_cascade;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [1:0]  cfg_addr_i = '0;
  logic [12:0] cfg_wdata_i = '0;
  logic [47:0] plane_cnt_i = '0;
  logic [12:0] cas_i = '0;
  logic [12:0] cas_o;
  logic [8:0]  aux_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  score_cascade i_score_cascade (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i),
    .cfg_wdata_i(cfg_wdata_i), .plane_cnt_i(plane_cnt_i), .cas_i(cas_i),
    .cas_o(cas_o), .aux_o(aux_o)
  );

  localparam logic [47:0] CNT_A  = {6'd8, 6'd7, 6'd6, 6'd5, 6'd4, 6'd3, 6'd2, 6'd1};
  localparam logic [47:0] ALL32  = {8{6'd32}};
  localparam logic [47:0] TOP32  = {6'd32, 42'd0};

  // {counts, fmt{aux_wtd,sgn,grp}, offset, cas_in, exp_cas, exp_aux}
  localparam int N_VEC = 11;
  localparam logic [99:0] VEC [N_VEC] = '{
    {CNT_A, 4'b0000, 13'sd0,    13'sd0,    13'sd36,    9'd36},
    {CNT_A, 4'b1011, 13'sd0,    13'sd0,    13'sd1793,  9'd255},
    {CNT_A, 4'b1111, 13'sd0,    13'sd0,    -13'sd255,  -9'sd255},
    {CNT_A, 4'b1001, 13'sd0,    13'sd0,    13'sd56,    9'd56},
    {CNT_A, 4'b1101, 13'sd0,    13'sd0,    -13'sd24,   -9'sd24},
    {CNT_A, 4'b0010, -13'sd100, 13'sd1000, 13'sd1058,  9'd36},
    {CNT_A, 4'b1100, 13'sd0,    13'sd0,    -13'sd36,   -9'sd36},
    {ALL32, 4'b0011, 13'sd0,    13'sd0,    13'sd4095,  9'd256},
    {TOP32, 4'b1111, 13'sd0,    -13'sd1,   13'h1000,   9'h100},
    {48'd0, 4'b0000, 13'h1000,  13'h1000,  13'h1000,   9'd0},
    {CNT_A, 4'b1010, 13'sd50,   -13'sd8,   13'sd200,   9'd158}
  };

  task automatic chk(string tag, logic signed [15:0] act, logic signed [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic cfg(logic [1:0] a, logic [12:0] d);
    cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
    wait_cyc(1);
    cfg_we_i = 1'b0;
  endtask

  // one-cycle count pulse of value 10 on plane 0, arrival after 3+d edges (R4)
  task automatic pulse_delay(int d);
    cfg(2'd2, 13'(d));
    plane_cnt_i = '0; cas_i = '0;
    wait_cyc(20);
    plane_cnt_i = {42'd0, 6'd10};
    wait_cyc(1);
    plane_cnt_i = '0;
    wait_cyc(3 + d - 2);
    chk($sformatf("R4 before arrival d=%0d", d), $signed(cas_o), 16'sd0);
    wait_cyc(1);
    chk($sformatf("R4 arrival d=%0d", d), $signed(cas_o), 16'sd10);
    wait_cyc(1);
    chk($sformatf("R4 after arrival d=%0d", d), $signed(cas_o), 16'sd0);
  endtask

  initial begin
    @(negedge clk_i);
    @(negedge clk_i);
    chk("R8 reset cas_o", $signed(cas_o), 16'sd0);
    chk("R8 reset aux_o", {7'd0, aux_o}, 16'sd0);
    rst_ni = 1'b1;
    wait_cyc(2);
    chk("R8 cas_o after release", $signed(cas_o), 16'sd0);

    // table walk: R1 R2 R3 R5 R6
    for (int v = 0; v < N_VEC; v++) begin
      cfg(2'd0, {9'd0, VEC[v][51:48]});
      cfg(2'd1, VEC[v][47:35]);
      cfg(2'd2, 13'd0);
      plane_cnt_i = VEC[v][99:52];
      cas_i = VEC[v][34:22];
      wait_cyc(8);
      chk($sformatf("R1/R2/R3/R5 vec %0d cas_o", v), $signed(cas_o), $signed(VEC[v][21:9]));
      chk($sformatf("R6 vec %0d aux_o", v), {7'd0, aux_o}, {7'd0, VEC[v][8:0]});
    end

    // R5 boundaries
    cfg(2'd0, 13'd0);
    plane_cnt_i = '0;
    cfg(2'd1, 13'sd4095); cas_i = 13'sd0;  wait_cyc(6);
    chk("R5 exact upper limit", $signed(cas_o), 16'sd4095);
    cas_i = 13'sd1; wait_cyc(2);
    chk("R5 one past upper limit", $signed(cas_o), 16'sd4095);
    cas_i = -13'sd1; wait_cyc(2);
    chk("R5 just under limit", $signed(cas_o), 16'sd4094);

    // R4 cascade input latency
    cfg(2'd1, 13'd0); cas_i = '0; wait_cyc(8);
    cas_i = 13'sd7;
    wait_cyc(1);
    chk("R4 cas_i after one edge", $signed(cas_o), 16'sd7);
    cas_i = '0;
    wait_cyc(1);
    chk("R4 cas_i removed", $signed(cas_o), 16'sd0);

    // R4 delay taps
    pulse_delay(0);
    pulse_delay(5);
    pulse_delay(15);

    // R7 reserved address has no effect
    cfg(2'd2, 13'd0);
    cfg(2'd0, 13'd0);
    plane_cnt_i = CNT_A;
    wait_cyc(8);
    cfg(2'd3, 13'h1FFF);
    wait_cyc(8);
    chk("R7 addr3 leaves offset/format", $signed(cas_o), 16'sd36);
    chk("R7 addr3 leaves aux select", {7'd0, aux_o}, 16'sd36);
    pulse_delay(2);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule